// File: doc/BRIEF.md
# Central Bus Grant Hub with Overlapped Arbitration

This block arbitrates a single shared, multiplexed bus among several masters. Every master owns a private request line and a private grant line, both running point-to-point to one central arbiter. The arbiter is synchronous: it takes its decisions on rising clock edges and never asserts more than one grant. Priority rotates round-robin, and the search starts at the master after the one granted most recently.

Grant and ownership are deliberately decoupled. The arbiter may hand the grant to the next master while the current owner is still partway through its transaction. Each master has a small start controller. That controller raises the master's request while work is pending. It begins a transaction only when it holds the grant and sees the bus idle, meaning both the frame line and the initiator-ready line are low. When a master is taking the bus, its request stays up if more work follows and drops if this is its last transaction. The behavioural master drives frame and initiator-ready for the length of its transfer, starting in the cycle after the start pulse.

Top module: `bus_grant_hub`

## Requirements
- R1: While reset is held and in the first cycle after it, all request, grant and start outputs are low.
- R2: No more than one grant bit is high in any cycle.
- R3: A grant bit is high only if that master's request was high in the previous cycle. With no request pending, the grant vector becomes all zero.
- R4: A start pulse for master i appears one cycle after an edge at which grant i and request i were high and frame and initiator-ready were both low. The pulse lasts exactly one cycle.
- R5: The cycle after a master starts, the grant moves to another requesting master even though the transaction is still running. That master starts in the first cycle after an edge at which the bus is idle. Every pending transaction of every master is eventually started exactly once.
- R6: Grants rotate round-robin, beginning after the most recent grantee. Out of reset, master 0 is searched first.
- R7: If the current grantee is the only requester, its grant stays high without a gap across its back-to-back transactions.
- R8: At the edge where a master starts, its request takes the value of its more-work input. A master with a single transaction therefore drops its request in the same cycle as its start pulse.
- R9: If a granted master's request falls before it starts, its grant falls one cycle later, and that master does not start.
- R10: A granted, requesting master that has not yet started keeps its grant unchanged while it waits for the bus to go idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| job_valid_i | input | N_MASTERS | Master i has at least one transaction pending |
| job_more_i | input | N_MASTERS | Master i has another transaction after the pending one |
| bus_frame_i | input | 1 | Shared frame line, high while a transaction's address or non-final data phases run |
| bus_irdy_i | input | 1 | Shared initiator-ready line, high until the final transfer completes |
| req_o | output | N_MASTERS | Registered request line of each master |
| gnt_o | output | N_MASTERS | Registered grant line of each master, zero or one-hot |
| start_o | output | N_MASTERS | One-cycle pulse: master i takes the bus |

## Verification
The first directed pattern is a lone single-transaction master. It pins down the exact request, grant and start latency and shows the request falling at start. The second is two masters with a long transfer, which separates a grant that moves during a transaction from a master that wrongly starts on a busy bus. The remaining directed patterns are: all four masters with two transactions each, which exposes any fault in rotation order; a lone master with three transactions, which distinguishes parking from a drop-and-regrant; and a grantee that withdraws its request, which tests rearbitration. Forty randomized rounds follow, with random transaction counts and transfer lengths. On every cycle, a bus model confirms the rules for grant count and idle-only starts, and the number of starts per master is compared with the work that master was given.

// File: rtl/bgh_pkg.sv
package bgh_pkg;
  // Index width for a vector of n entries; at least one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bgh_rr_pick.sv
module bgh_rr_pick #(
  parameter int N_MASTERS = 4,
  localparam int IW = bgh_pkg::idx_bits(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [IW-1:0]        base_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o
);
  int cand;

  // Scan downwards so the nearest candidate after base wins; base itself is last.
  always_comb begin
    found_o = 1'b0;
    idx_o   = base_i;
    cand    = 0;
    for (int k = N_MASTERS; k >= 1; k--) begin
      cand = (int'(base_i) + k) % N_MASTERS;
      if (req_i[cand]) begin
        found_o = 1'b1;
        idx_o   = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/bgh_arbiter.sv
module bgh_arbiter #(
  parameter int N_MASTERS = 4,
  localparam int IW = bgh_pkg::idx_bits(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] start_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  logic [N_MASTERS-1:0] gnt_q, gnt_nx;
  logic [IW-1:0]        last_q, pick;
  logic                 found, hold;

  bgh_rr_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .req_i  (req_i),
    .base_i (last_q),
    .found_o(found),
    .idx_o  (pick)
  );

  // Keep the grant while its owner still requests and has not yet taken the bus.
  always_comb begin
    hold   = |(gnt_q & req_i & ~start_i);
    gnt_nx = '0;
    if (found) gnt_nx[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      last_q <= IW'(N_MASTERS - 1);
    end else if (!hold) begin
      gnt_q <= gnt_nx;
      if (found) last_q <= pick;
    end
  end

  assign gnt_o = gnt_q;

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  assert_gnt_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt_q & ~$past(req_i)) == '0);

  assert_drop_rearb_R9: assert property (@(posedge clk) disable iff (rst)
    (|(gnt_q & ~req_i)) |=> ((gnt_q & $past(gnt_q & ~req_i)) == '0));

  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (|(gnt_q & req_i & ~start_i)) |=> $stable(gnt_q));
endmodule

// File: rtl/bgh_starter.sv
module bgh_starter (
  input  logic clk,
  input  logic rst,
  input  logic gnt_i,
  input  logic job_valid_i,
  input  logic job_more_i,
  input  logic bus_frame_i,
  input  logic bus_irdy_i,
  output logic req_o,
  output logic start_o
);
  logic req_q, start_q, take;

  // Take the bus only with a live grant, a live request and an idle bus.
  always_comb take = gnt_i & req_q & ~bus_frame_i & ~bus_irdy_i & ~start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= take;
      req_q   <= take ? job_more_i : job_valid_i;
    end
  end

  assign req_o   = req_q;
  assign start_o = start_q;

  assert_start_idle_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(gnt_i && !bus_frame_i && !bus_irdy_i));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  assert_req_at_start_R8: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (req_q == $past(job_more_i)));
endmodule

// File: rtl/bus_grant_hub.sv
module bus_grant_hub #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] job_valid_i,
  input  logic [N_MASTERS-1:0] job_more_i,
  input  logic                 bus_frame_i,
  input  logic                 bus_irdy_i,
  output logic [N_MASTERS-1:0] req_o,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic [N_MASTERS-1:0] start_o
);
  logic [N_MASTERS-1:0] req_w, gnt_w, start_w;

  bgh_arbiter #(.N_MASTERS(N_MASTERS)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_w),
    .start_i(start_w),
    .gnt_o  (gnt_w)
  );

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_master
    bgh_starter u_start (
      .clk        (clk),
      .rst        (rst),
      .gnt_i      (gnt_w[g]),
      .job_valid_i(job_valid_i[g]),
      .job_more_i (job_more_i[g]),
      .bus_frame_i(bus_frame_i),
      .bus_irdy_i (bus_irdy_i),
      .req_o      (req_w[g]),
      .start_o    (start_w[g])
    );
  end

  assign req_o   = req_w;
  assign gnt_o   = gnt_w;
  assign start_o = start_w;

  assert_one_starter_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_w));
endmodule

// File: tb/tb_bus_grant_hub.sv
module tb_bus_grant_hub;
  localparam int N = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst;
  logic [N-1:0] job_valid, job_more;
  logic         frame, irdy;
  wire  [N-1:0] req, gnt, start;

  bus_grant_hub #(.N_MASTERS(N)) dut (
    .clk(clk), .rst(rst), .job_valid_i(job_valid), .job_more_i(job_more),
    .bus_frame_i(frame), .bus_irdy_i(irdy),
    .req_o(req), .gnt_o(gnt), .start_o(start)
  );

  int pending [N];
  int start_cnt [N];
  int slog [64];
  int nlog, cnt, txn_len, cyc;
  bit rand_len;
  int checks, fails;
  logic [N-1:0] prev_gnt;
  bit prev_idle;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Behavioural bus and masters, plus per-cycle rule monitor.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (rst) begin
      cnt = 0; nlog = 0;
      for (int i = 0; i < N; i++) start_cnt[i] = 0;
    end else begin
      chk($countones(gnt) <= 1, "R2 grant count", $countones(gnt), 1);
      if (start != '0) begin
        for (int i = 0; i < N; i++) if (start[i]) begin
          chk(prev_gnt[i] && prev_idle, "R4 start legality", {prev_gnt[i], prev_idle}, 3);
          chk(cnt == 0, "R5 start on busy bus", cnt, 0);
          if (pending[i] > 0) pending[i]--;
          start_cnt[i]++;
          if (nlog < 64) slog[nlog] = i;
          nlog++;
          cnt = (rand_len ? $urandom_range(1, 4) : txn_len) + 1;
        end
      end else if (cnt > 0) begin
        cnt--;
      end
    end
    frame = (cnt > 1);
    irdy  = (cnt > 0);
    for (int i = 0; i < N; i++) begin
      job_valid[i] = (pending[i] > 0);
      job_more[i]  = (pending[i] > 1);
    end
    prev_gnt  = gnt;
    prev_idle = !frame && !irdy;
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic do_reset();
    @(posedge clk); #5;
    rst = 1'b1;
    for (int i = 0; i < N; i++) pending[i] = 0;
    rand_len = 1'b0;
    repeat (3) step();
    chk(req == '0 && gnt == '0 && start == '0, "R1 in reset", {req, gnt, start}, 0);
    rst = 1'b0;
  endtask

  int exp_cnt [N];
  int done, guard;

  initial begin
    checks = 0; fails = 0; cyc = 0; txn_len = 1; rst = 1'b1;
    frame = 1'b0; irdy = 1'b0; job_valid = '0; job_more = '0;

    // T1: reset state
    do_reset();
    step();
    chk(req == '0 && gnt == '0 && start == '0, "R1 after reset", {req, gnt, start}, 0);

    // T2: lone single-transaction master 0
    do_reset();
    pending[0] = 1;
    step(); chk(req == 4'b0001, "R3 request raised", req, 1);
    step(); chk(gnt == 4'b0001, "R6 first grant to master 0", gnt, 1);
    step(); chk(start == 4'b0001, "R4 start pulse", start, 1);
            chk(req[0] == 1'b0, "R8 request drops at start", req[0], 0);
    step(); chk(start == '0, "R4 pulse one cycle", start, 0);
            chk(gnt == '0, "R3 no requests no grant", gnt, 0);

    // T3: hidden arbitration between masters 0 and 2
    do_reset();
    txn_len = 6;
    pending[0] = 1; pending[2] = 1;
    repeat (3) step();
    chk(start == 4'b0001, "R5 master 0 starts", start, 1);
    step();
    chk(gnt == 4'b0100 && frame, "R5 grant moves during transaction", {gnt, frame}, 9);
    for (int k = 1; k <= 7; k++) begin
      step();
      if (k < 7) begin
        chk(start == '0, "R5 waits for idle", start, 0);
        chk(gnt == 4'b0100, "R10 grant held while waiting", gnt, 4);
      end else begin
        chk(start == 4'b0100, "R5 starts at first idle edge", start, 4);
      end
    end

    // T4: round-robin rotation
    do_reset();
    txn_len = 1;
    for (int i = 0; i < N; i++) pending[i] = 2;
    guard = 0;
    while (nlog < 8 && guard < 200) begin step(); guard++; end
    for (int k = 0; k < 8; k++) chk(slog[k] == k % N, "R6 rotation order", slog[k], k % N);

    // T5: parking on a lone requester
    do_reset();
    txn_len = 2;
    pending[1] = 3;
    guard = 0;
    while (!gnt[1] && guard < 10) begin step(); guard++; end
    done = 0;
    for (int k = 0; k < 60; k++) begin
      if (done == 3) break;
      chk(gnt == 4'b0010, "R7 grant parked", gnt, 2);
      if (start[1]) done++;
      step();
    end
    chk(done == 3, "R7 three starts", done, 3);
    chk(gnt == '0, "R3 grant clears after last", gnt, 0);

    // T6: grantee withdraws before starting
    do_reset();
    txn_len = 10;
    pending[0] = 1;
    repeat (3) step();
    pending[3] = 1;
    step(); step();
    chk(gnt == 4'b1000, "R5 grant to waiting master 3", gnt, 8);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(gnt == 4'b1000 && start == '0, "R10 held on busy bus", {gnt, start}, 128);
    end
    pending[3] = 0;
    step(); chk(req[3] == 1'b0, "R9 request withdrawn", req[3], 0);
    step(); chk(gnt == '0, "R9 grant removed", gnt, 0);
    repeat (15) step();
    chk(start_cnt[3] == 0, "R9 no start after withdrawal", start_cnt[3], 0);

    // T7: randomized sweep
    for (int r = 0; r < 40; r++) begin
      do_reset();
      rand_len = 1'b1;
      for (int i = 0; i < N; i++) begin
        exp_cnt[i] = $urandom_range(0, 3);
        pending[i] = exp_cnt[i];
      end
      guard = 0;
      while (guard < 400) begin
        step(); guard++;
        if (pending[0] + pending[1] + pending[2] + pending[3] == 0 && cnt == 0) break;
      end
      for (int i = 0; i < N; i++)
        chk(start_cnt[i] == exp_cnt[i], "R5 all work started once", start_cnt[i], exp_cnt[i]);
    end

    finish_run();
  end
endmodule